// File: doc/BRIEF.md
# Card-Detect Interrupt Status Logic

This block holds the normal interrupt status and normal interrupt enable registers of an SD host controller. Its one event source is the card-detect line. A debounced card-present input is sampled every cycle. While the edge detector is armed, a rising edge latches an insertion event and a falling edge latches a removal event. The normal status is latched whatever the enable register holds. The enable register is applied only when the status word is read and when the interrupt output is formed.

When a card is already present at power-on, the block holds a hidden sticky insertion event. That event stays invisible until software sets the insertion enable bit, and software can clear it with a write-1-to-clear. The edge detector is armed only by the power-on reset. A software reset clears the status and enable registers and disarms the detector, so no further card-detect events are latched until the next power-on reset. The present-state bit keeps following the card-detect input throughout. Error status bits come in as plain inputs. They are returned unmasked in the upper part of the status word and gated by an error-enable register on their way to the interrupt output.

Top module: `cdi_card_irq`

## Requirements
- R1: After power-on reset, reads of the status word (sel 0) and of the enable word (sel 1) return zero in the normal half.
- R2: If the card-present input is high in the first cycle after power-on reset, a hidden insertion event is held; while the insertion enable bit (bit INS_BIT) is clear, the normal half of the status word reads zero and irq stays low.
- R3: Once the insertion enable bit is written to 1 while that power-on event is pending, the status word reads bit INS_BIT set from the cycle after the write, and irq is high.
- R4: The low NORM_W bits of a status read equal the latched normal status ANDed with the normal enable bits. An event latched while its enable bit is clear becomes visible when that enable bit is set later.
- R5: The upper ERR_W bits of a status read equal the err_sts input, with no masking.
- R6: While the detector is armed, a 0-to-1 change of card_present latches bit INS_BIT and a 1-to-0 change latches bit REM_BIT. Each appears in the status one clock after the change is sampled.
- R7: A sw_rst pulse clears normal status, the pending power-on event, normal enable and error enable. Until the next power-on reset, no card-detect edge latches any status bit.
- R8: The present-state word (sel 2) returns the card-present input in bit 0 one clock after it is sampled. It is unaffected by sw_rst and by any interrupt state.
- R9: A write to the status word clears every normal bit whose write-data bit is 1, including the pending power-on event. Bits written with 0 are kept. A card-detect event in the same cycle as a clear of its bit wins.
- R10: irq is high exactly when any bit of (normal status AND normal enable) or of (err_sts AND error enable) is set.
- R11: The enable word (sel 1) is read/write: normal enables in the low NORM_W bits, error enables in the upper ERR_W bits. Selector 3 reads zero, and writes to selectors 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; arms the edge detector |
| sw_rst | input | 1 | Controller software reset strobe |
| card_present | input | 1 | Debounced card-present level |
| err_sts | input | ERR_W | Error status bits from other logic |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector: 0 status, 1 enable, 2 present state, 3 unused |
| reg_wdata | input | NORM_W+ERR_W | Write data |
| reg_rdata | output | NORM_W+ERR_W | Read data for reg_sel, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NORM_W=8, ERR_W=4, INS_BIT=2 and REM_BIT=3. With these values it can sweep every one of the 256 pairings of error status and error enable, checking both the upper read half and irq. It also applies all 256 write-1-to-clear masks against a status holding both card events. It repeats power-on with the card present and absent, and issues software resets with a power-on event pending and with events latched. This exercises the sticky event and the one-shot arming directly at the ports.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_PRESENT = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/cdi_cd_edge.sv
module cdi_cd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst_i,
    input  logic card_i,
    output logic present_o,
    output logic por_evt_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic cp;
        logic init;
        logic armed;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cp    = card_i;
        st_d.init  = 1'b0;
        st_d.armed = st_q.armed & ~sw_rst_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cp    <= 1'b0;
            st_q.init  <= 1'b1;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign present_o = st_q.cp;
    assign por_evt_o = st_q.init & card_i;
    assign rise_o    = st_q.armed & ~st_q.init & card_i & ~st_q.cp;
    assign fall_o    = st_q.armed & ~st_q.init & ~card_i & st_q.cp;

    // R8: the present bit survives a software reset and keeps tracking
    a_r8_present_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_i |=> present_o == $past(card_i));

    // R7: detector stays disarmed after a software reset
    a_r7_no_edges_after_swrst: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_i |=> (!rise_o && !fall_o));

endmodule

// File: rtl/cdi_sts_regs.sv
module cdi_sts_regs #(
    parameter int NORM_W  = 16,
    parameter int ERR_W   = 16,
    parameter int INS_BIT = 6,
    parameter int REM_BIT = 7,
    localparam int DATA_W = NORM_W + ERR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_rst_i,
    input  logic                 wr_en_i,
    input  cdi_pkg::reg_sel_e    sel_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 por_evt_i,
    output logic [NORM_W-1:0]    norm_sts_o,
    output logic [NORM_W-1:0]    norm_en_o,
    output logic [ERR_W-1:0]     err_en_o
);

    typedef struct packed {
        logic [NORM_W-1:0] sts;
        logic              sticky;
        logic [NORM_W-1:0] nen;
        logic [ERR_W-1:0]  een;
    } regs_t;

    regs_t r_d, r_q;

    logic [NORM_W-1:0] ev;
    logic [NORM_W-1:0] clr;
    logic              wr_sts, wr_en;

    for (genvar i = 0; i < NORM_W; i++) begin : g_ev
        if (i == INS_BIT) begin : g_ins
            assign ev[i] = rise_i;
        end else if (i == REM_BIT) begin : g_rem
            assign ev[i] = fall_i;
        end else begin : g_none
            assign ev[i] = 1'b0;
        end
    end

    assign wr_sts = wr_en_i && (sel_i == cdi_pkg::SEL_STATUS);
    assign wr_en  = wr_en_i && (sel_i == cdi_pkg::SEL_ENABLE);
    assign clr    = wr_sts ? wdata_i[NORM_W-1:0] : '0;

    always_comb begin
        r_d        = r_q;
        r_d.sts    = (r_q.sts & ~clr) | ev;
        r_d.sticky = (r_q.sticky & ~clr[INS_BIT]) | por_evt_i;
        if (wr_en) begin
            r_d.nen = wdata_i[NORM_W-1:0];
            r_d.een = wdata_i[DATA_W-1:NORM_W];
        end
        if (sw_rst_i) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign norm_sts_o = r_q.sts | (NORM_W'(r_q.sticky) << INS_BIT);
    assign norm_en_o  = r_q.nen;
    assign err_en_o   = r_q.een;

    // R7: software reset empties status and enables
    a_r7_swrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_i |=> (norm_sts_o == '0 && norm_en_o == '0 && err_en_o == '0));

    // R9: a written 1 clears the insertion bit, sticky event included
    a_r9_w1c_ins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata_i[INS_BIT] && !rise_i && !por_evt_i) |=> !norm_sts_o[INS_BIT]);

    // R9: without a clear the insertion bit holds
    a_r9_hold_ins: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst_i && norm_sts_o[INS_BIT] && !(wr_sts && wdata_i[INS_BIT])) |=> norm_sts_o[INS_BIT]);

endmodule

// File: rtl/cdi_rd_view.sv
module cdi_rd_view #(
    parameter int NORM_W  = 16,
    parameter int ERR_W   = 16,
    localparam int DATA_W = NORM_W + ERR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cdi_pkg::reg_sel_e sel_i,
    input  logic [NORM_W-1:0] norm_sts_i,
    input  logic [NORM_W-1:0] norm_en_i,
    input  logic [ERR_W-1:0]  err_en_i,
    input  logic [ERR_W-1:0]  err_sts_i,
    input  logic              present_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    logic [NORM_W-1:0] vis;

    assign vis = norm_sts_i & norm_en_i;

    always_comb begin
        case (sel_i)
            cdi_pkg::SEL_STATUS:  rdata_o = {err_sts_i, vis};
            cdi_pkg::SEL_ENABLE:  rdata_o = {err_en_i, norm_en_i};
            cdi_pkg::SEL_PRESENT: rdata_o = DATA_W'(present_i);
            default:              rdata_o = '0;
        endcase
    end

    assign irq_o = (|vis) | (|(err_sts_i & err_en_i));

    // R4: nothing outside the enable mask is visible in a status read
    a_r4_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == cdi_pkg::SEL_STATUS) |-> ((rdata_o[NORM_W-1:0] & ~norm_en_i) == '0));

    // R10: all enables clear means no interrupt
    a_r10_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_en_i == '0 && err_en_i == '0) |-> !irq_o);

endmodule

// File: rtl/cdi_card_irq.sv
module cdi_card_irq #(
    parameter int NORM_W  = 16,
    parameter int ERR_W   = 16,
    parameter int INS_BIT = 6,
    parameter int REM_BIT = 7,
    localparam int DATA_W = NORM_W + ERR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              card_present,
    input  logic [ERR_W-1:0]  err_sts,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    cdi_pkg::reg_sel_e sel;
    logic              present, por_evt, rise, fall;
    logic [NORM_W-1:0] norm_sts, norm_en;
    logic [ERR_W-1:0]  err_en;

    assign sel = cdi_pkg::reg_sel_e'(reg_sel);

    cdi_cd_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst_i  (sw_rst),
        .card_i    (card_present),
        .present_o (present),
        .por_evt_o (por_evt),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    cdi_sts_regs #(
        .NORM_W  (NORM_W),
        .ERR_W   (ERR_W),
        .INS_BIT (INS_BIT),
        .REM_BIT (REM_BIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst_i   (sw_rst),
        .wr_en_i    (reg_wr),
        .sel_i      (sel),
        .wdata_i    (reg_wdata),
        .rise_i     (rise),
        .fall_i     (fall),
        .por_evt_i  (por_evt),
        .norm_sts_o (norm_sts),
        .norm_en_o  (norm_en),
        .err_en_o   (err_en)
    );

    cdi_rd_view #(
        .NORM_W (NORM_W),
        .ERR_W  (ERR_W)
    ) u_view (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel),
        .norm_sts_i (norm_sts),
        .norm_en_i  (norm_en),
        .err_en_i   (err_en),
        .err_sts_i  (err_sts),
        .present_i  (present),
        .rdata_o    (reg_rdata),
        .irq_o      (irq)
    );

endmodule

// File: tb/cdi_card_irq_tb.sv
module cdi_card_irq_tb;

    localparam int NW = 8;
    localparam int EW = 4;
    localparam int INS = 2;
    localparam int REM = 3;
    localparam int DW = NW + EW;
    localparam logic [NW-1:0] INSM = NW'(1) << INS;
    localparam logic [NW-1:0] REMM = NW'(1) << REM;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_rst = 1'b0;
    logic          card_present = 1'b0;
    logic [EW-1:0] err_sts = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    cdi_card_irq #(.NORM_W(NW), .ERR_W(EW), .INS_BIT(INS), .REM_BIT(REM)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .card_present(card_present),
        .err_sts(err_sts), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [DW-1:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic setcard(input logic v);
        @(negedge clk);
        card_present = v;
        @(negedge clk);
    endtask

    task automatic por(input logic v);
        @(negedge clk);
        rst_n = 1'b0; card_present = v; sw_rst = 1'b0; reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_swrst();
        @(negedge clk);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d;

        // power-on with a card present
        por(1'b1);
        rd(2'd0, d); chk("R1 status after reset", d[NW-1:0], 0);
        rd(2'd1, d); chk("R1 enable after reset", d, 0);
        chk("R2 irq low with hidden event", irq, 0);
        rd(2'd2, d); chk("R8 present after reset", d, 1);
        repeat (3) @(negedge clk);
        rd(2'd0, d); chk("R2 event stays hidden", d[NW-1:0], 0);

        // enabling insertion reveals the sticky event
        wr(2'd1, DW'(INSM));
        rd(2'd0, d); chk("R3 insert visible after enable", d[NW-1:0], INSM);
        chk("R3 irq raised", irq, 1);
        rd(2'd1, d); chk("R11 enable readback", d, DW'(INSM));

        // write-0 keeps, write-1 clears (sticky included)
        wr(2'd0, '0);
        rd(2'd0, d); chk("R9 zero write keeps", d[NW-1:0], INSM);
        wr(2'd0, DW'(INSM));
        rd(2'd0, d); chk("R9 one write clears sticky", d[NW-1:0], 0);
        chk("R10 irq drops after clear", irq, 0);

        // removal latched while disabled, visible once enabled
        setcard(1'b0);
        rd(2'd0, d); chk("R4 removal hidden", d[NW-1:0], 0);
        rd(2'd2, d); chk("R8 present follows removal", d, 0);
        wr(2'd1, DW'(INSM | REMM));
        rd(2'd0, d); chk("R4 removal shown on enable", d[NW-1:0], REMM);
        chk("R6 removal edge latched", d[NW-1:0], REMM);
        setcard(1'b1);
        rd(2'd0, d); chk("R6 insertion edge latched", d[NW-1:0], INSM | REMM);
        wr(2'd0, DW'(INSM | REMM));

        // spare selectors
        wr(2'd3, '1);
        rd(2'd3, d); chk("R11 spare reads zero", d, 0);
        wr(2'd2, '0);
        rd(2'd2, d); chk("R11 present not writable", d, 1);
        rd(2'd1, d); chk("R11 spare write ignored", d, DW'(INSM | REMM));

        // error half: all status x enable pairings
        wr(2'd1, '0);
        for (int es = 0; es < (1 << EW); es++) begin
            for (int en = 0; en < (1 << EW); en++) begin
                wr(2'd1, {EW'(en), NW'(0)});
                err_sts = EW'(es);
                rd(2'd0, d);
                chk("R5 error half unmasked", d[DW-1:NW], es);
                chk("R10 irq from errors", irq, ((es & en) != 0) ? 1 : 0);
            end
        end
        err_sts = '0;
        wr(2'd1, DW'({NW{1'b1}}));

        // every clear mask against both card events
        for (int m = 0; m < (1 << NW); m++) begin
            setcard(1'b0);
            setcard(1'b1);
            wr(2'd0, DW'(m));
            rd(2'd0, d);
            chk("R9 clear mask sweep", d[NW-1:0], (INSM | REMM) & ~NW'(m));
            wr(2'd0, DW'({NW{1'b1}}));
        end

        // event wins over a same-cycle clear
        @(negedge clk);
        card_present = 1'b0; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = DW'(REMM);
        @(negedge clk);
        reg_wr = 1'b0;
        rd(2'd0, d); chk("R9 event beats clear", d[NW-1:0], REMM);

        // software reset: clears, disarms, leaves present alone
        wr(2'd1, '1);
        pulse_swrst();
        rd(2'd0, d); chk("R7 status cleared", d[NW-1:0], 0);
        rd(2'd1, d); chk("R7 enables cleared", d, 0);
        rd(2'd2, d); chk("R8 present kept over reset", d, 0);
        wr(2'd1, DW'({NW{1'b1}}));
        setcard(1'b1);
        rd(2'd2, d); chk("R8 present follows after reset", d, 1);
        rd(2'd0, d); chk("R7 insertion ignored after reset", d[NW-1:0], 0);
        chk("R7 irq stays low", irq, 0);
        setcard(1'b0);
        rd(2'd0, d); chk("R7 removal ignored after reset", d[NW-1:0], 0);

        // power-on without a card: no sticky, detector armed again
        por(1'b0);
        wr(2'd1, DW'(INSM));
        rd(2'd0, d); chk("R2 no event without card", d[NW-1:0], 0);
        setcard(1'b1);
        rd(2'd0, d); chk("R6 rearmed by power-on", d[NW-1:0], INSM);

        // software reset drops a pending power-on event
        por(1'b1);
        pulse_swrst();
        wr(2'd1, DW'(INSM));
        rd(2'd0, d); chk("R7 sticky dropped by reset", d[NW-1:0], 0);

        finish_run();
    end

endmodule